// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between an internal request stream and an external asynchronous static RAM of 2M bytes. Each accepted request is a single read or a single write of one byte. The block turns it into a strobe sequence on the memory pins that meets the part's minimum access, pulse, setup and hold times. A read returns its byte with a one-cycle completion pulse. A write also ends with that pulse.

All timing comes from a clock-period parameter given in nanoseconds. Each memory minimum is divided by that period and rounded up, and every phase lasts at least one cycle. The memory has two selects of opposite polarity, an active-low output enable and an active-low write enable. The shared 8-bit data bus is split into an outgoing byte, a driver enable and an incoming byte. Writes are ended by the write enable, and output enable stays high for the whole write.

The request side uses valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low from acceptance until the block is free again, so it also serves as the busy flag, and the requester must hold its fields stable while it waits. The response side has no back-pressure: `rsp_valid` is high for exactly one cycle, and the consumer must take `rsp_rdata` in that cycle.

Top module: `sram_ctrl`

## Requirements
- R1: During and directly after reset, both selects are inactive (`mem_sel_n`=1, `mem_sel`=0), `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0, `rsp_valid`=0 and `req_ready`=1.
- R2: A request is taken only on an edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the next cycle until the access and any turnaround gap have finished, so a request held high meanwhile is not taken twice.
- R3: The memory is selected (`mem_sel_n`=0 with `mem_sel`=1) only during an access. The two selects always carry opposite values.
- R4: A read holds `mem_oe_n` low, `mem_we_n` high, the data drivers off and the address stable for RD_CYC = ceil(max(25, 25, 12) ns / CLK_NS) cycles, which is 2 at 20 ns. The input byte is registered on the last of those edges.
- R5: A read ends with `rsp_valid` high for exactly one cycle, with `rsp_rdata` equal to the byte last written to that address.
- R6: A write holds `mem_we_n` low for WP_CYC = ceil(max(18, 12, 15) ns / CLK_NS) cycles, which is 1 at 20 ns. Throughout that time `mem_oe_n` is high, the drivers are on, and address and data are stable. This gives at least 18 ns of pulse, 12 ns of data setup and 15 ns of address setup before the rising edge.
- R7: After `mem_we_n` rises, the select, address and driven data stay unchanged for at least one more cycle, so that the write cycle lasts at least ceil(25 ns / CLK_NS) cycles.
- R8: `mem_dq_oe` is never high while `mem_oe_n` is low. After a read, `req_ready` stays low for GAP_CYC = ceil(8 ns / CLK_NS) cycles (at least 1) past the edge that raises `mem_oe_n`. As a result, at least one idle cycle separates a read's output enable from the block's own drivers.
- R9: A write ends with a single-cycle `rsp_valid`, and `rsp_rdata` keeps the value of the previous read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block free; low means busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Registered read byte |
| mem_addr | output | 21 | Memory address |
| mem_sel_n | output | 1 | Active-low select |
| mem_sel | output | 1 | Active-high select |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 8 | Byte to drive onto the data bus |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_in | input | 8 | Byte read from the data bus |

## Verification
The assertions assume two things about the inputs. First, a requester keeps `req_valid` and its fields steady until it is accepted. Second, the memory returns valid data no later than the rated access time after address and output enable settle. The stimulus meets the first by driving requests only through a task that holds them until acceptance. It meets the second with a memory model that returns unknown data until 25 ns after the last change of address, select or output enable. The same model writes only on the rising write enable. It measures pulse width, data setup and address setup at that edge.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_GAP,
    ST_WPULSE,
    ST_WREC
  } seq_state_e;

  // nanoseconds to whole cycles, rounded up, never below one
  function automatic int ns2cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int AW      = 21,
  parameter int DW      = 8,
  parameter int CW      = 2,
  parameter int RD_CYC  = 2,
  parameter int WP_CYC  = 1,
  parameter int REC_CYC = 1,
  parameter int GAP_CYC = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          tmr_done,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          busy,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_sel_n,
  output logic          mem_sel,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);
  localparam logic [CW-1:0] RD_LD  = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] WP_LD  = CW'(WP_CYC - 1);
  localparam logic [CW-1:0] REC_LD = CW'(REC_CYC - 1);
  localparam logic [CW-1:0] GAP_LD = CW'(GAP_CYC - 1);

  seq_state_e state;
  logic       take;

  assign busy = (state != ST_IDLE);
  assign take = (state == ST_IDLE) && req_valid;

  // phase length is loaded on every edge that enters a timed phase
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      ST_IDLE:   if (req_valid) begin tmr_load = 1'b1; tmr_val = req_write ? WP_LD : RD_LD; end
      ST_READ:   if (tmr_done)  begin tmr_load = 1'b1; tmr_val = GAP_LD; end
      ST_WPULSE: if (tmr_done)  begin tmr_load = 1'b1; tmr_val = REC_LD; end
      default:   ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      mem_addr   <= '0;
      mem_sel_n  <= 1'b1;
      mem_sel    <= 1'b0;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        ST_IDLE: if (take) begin
          mem_addr  <= req_addr;
          mem_sel_n <= 1'b0;
          mem_sel   <= 1'b1;
          if (req_write) begin
            mem_dq_out <= req_wdata;
            mem_dq_oe  <= 1'b1;
            mem_we_n   <= 1'b0;
            state      <= ST_WPULSE;
          end else begin
            mem_oe_n <= 1'b0;
            state    <= ST_READ;
          end
        end
        ST_READ: if (tmr_done) begin
          rsp_rdata <= mem_dq_in;
          rsp_valid <= 1'b1;
          mem_oe_n  <= 1'b1;
          mem_sel_n <= 1'b1;
          mem_sel   <= 1'b0;
          state     <= ST_GAP;
        end
        ST_GAP: if (tmr_done) state <= ST_IDLE;
        ST_WPULSE: if (tmr_done) begin
          mem_we_n <= 1'b1;
          state    <= ST_WREC;
        end
        ST_WREC: if (tmr_done) begin
          mem_dq_oe <= 1'b0;
          mem_sel_n <= 1'b1;
          mem_sel   <= 1'b0;
          rsp_valid <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int CLK_NS       = 20,
  parameter int AW           = 21,
  parameter int DW           = 8,
  parameter int T_ACC_NS     = 25,
  parameter int T_RCYC_NS    = 25,
  parameter int T_OEACC_NS   = 12,
  parameter int T_WPULSE_NS  = 18,
  parameter int T_WCYC_NS    = 25,
  parameter int T_DSETUP_NS  = 12,
  parameter int T_ASETUP_NS  = 15,
  parameter int T_OFF_NS     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_sel_n,
  output logic          mem_sel,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);
  localparam int RD_CYC  = ns2cyc(imax(imax(T_ACC_NS, T_RCYC_NS), T_OEACC_NS), CLK_NS);
  localparam int WP_CYC  = ns2cyc(imax(imax(T_WPULSE_NS, T_DSETUP_NS), T_ASETUP_NS), CLK_NS);
  localparam int WC_CYC  = ns2cyc(T_WCYC_NS, CLK_NS);
  localparam int REC_CYC = (WC_CYC - WP_CYC < 1) ? 1 : (WC_CYC - WP_CYC);
  localparam int GAP_CYC = ns2cyc(T_OFF_NS, CLK_NS);
  localparam int MAX_CYC = imax(imax(RD_CYC, WP_CYC), imax(REC_CYC, GAP_CYC));
  localparam int CW      = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_done;
  logic          busy;

  assign req_ready = ~busy;

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  sram_seq #(
    .AW(AW), .DW(DW), .CW(CW),
    .RD_CYC(RD_CYC), .WP_CYC(WP_CYC), .REC_CYC(REC_CYC), .GAP_CYC(GAP_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .tmr_done   (tmr_done),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .busy       (busy),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .mem_addr   (mem_addr),
    .mem_sel_n  (mem_sel_n),
    .mem_sel    (mem_sel),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .mem_dq_in  (mem_dq_in)
  );
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int AW = 21,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [AW-1:0] mem_addr,
  input logic          mem_sel_n,
  input logic          mem_sel,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic [DW-1:0] mem_dq_out,
  input logic          mem_dq_oe
);
  a_r2_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  a_r3_select_pair: assert property (@(posedge clk) disable iff (!rst_n)
    mem_sel_n != mem_sel);

  a_r4_read_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> mem_we_n && !mem_sel_n && !mem_dq_oe);

  a_r4_read_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n && $past(!mem_oe_n) |-> $stable(mem_addr));

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r6_write_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n && mem_dq_oe && !mem_sel_n);

  a_r6_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n && $past(!mem_we_n) |-> $stable(mem_addr) && $stable(mem_dq_out));

  a_r7_hold_after_we: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe && !mem_sel_n && $stable(mem_addr) && $stable(mem_dq_out));

  a_r8_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  a_r8_gap_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> !req_ready);
endmodule

bind sram_ctrl sram_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .mem_addr   (mem_addr),
  .mem_sel_n  (mem_sel_n),
  .mem_sel    (mem_sel),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_dq_out (mem_dq_out),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_ctrl_test.sv
`timescale 1ns/1ps
module sram_ctrl_test;
  localparam int AW = 21;
  localparam int DW = 8;
  localparam int RD_EXP  = 2;   // ceil(25/20)
  localparam int WP_EXP  = 1;   // ceil(18/20)
  localparam int GAP_EXP = 1;   // ceil(8/20)

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [DW-1:0] mem_dq_out;
  logic [DW-1:0] mem_dq_in;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;   // 50 MHz

  sram_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [DW-1:0] store [int];
  realtime t_chg = 0, t_wfall = 0, t_dchg = 0, t_achg = 0;
  wire selected = (mem_sel_n === 1'b0) && (mem_sel === 1'b1);

  always @(mem_addr or mem_oe_n or mem_sel_n or mem_sel) t_chg = $realtime;
  always @(mem_addr) t_achg = $realtime;
  always @(mem_dq_out) t_dchg = $realtime;
  always @(negedge mem_we_n) t_wfall = $realtime;

  always begin
    #1;
    if (selected && mem_oe_n === 1'b0 && mem_we_n === 1'b1 && ($realtime - t_chg) >= 25.0)
      mem_dq_in = store.exists(int'(mem_addr)) ? store[int'(mem_addr)] : 8'h00;
    else
      mem_dq_in = 'x;
  end

  always @(posedge mem_we_n) begin
    if (selected && mem_dq_oe === 1'b1) begin
      check(($realtime - t_wfall) >= 18.0, "R6", "write pulse ns", 32'($rtoi($realtime - t_wfall)), 18);
      check(($realtime - t_dchg) >= 12.0, "R6", "data setup ns", 32'($rtoi($realtime - t_dchg)), 12);
      check(($realtime - t_achg) >= 15.0, "R6", "addr setup ns", 32'($rtoi($realtime - t_achg)), 15);
      store[int'(mem_addr)] = mem_dq_out;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct { bit wr; logic [DW-1:0] d; } exp_t;
  exp_t exp_q[$];
  logic [DW-1:0] shadow [int];
  logic [DW-1:0] last_rd = '0;

  task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    exp_t e;
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    e.wr = wr;
    e.d  = wr ? d : (shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00);
    if (wr) shadow[int'(a)] = d;
    exp_q.push_back(e);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  int outstanding = 0;
  int oe_low = 0, we_low = 0, oe_off = 99;
  bit prev_dq_oe = 0, prev_we_n = 1, prev_oe_n = 1;

  always @(negedge clk) if (rst_n) begin
    exp_t e;
    if (rsp_valid) begin
      outstanding--;
      if (exp_q.size() == 0) check(0, "R5", "response without request", 0, 1);
      else begin
        e = exp_q.pop_front();
        if (e.wr) check(rsp_rdata === last_rd, "R9", "rdata after write", 32'(rsp_rdata), 32'(last_rd));
        else begin
          check(rsp_rdata === e.d, "R5", "read byte", 32'(rsp_rdata), 32'(e.d));
          last_rd = e.d;
        end
      end
    end
    if (outstanding > 0 && req_ready) check(0, "R2", "ready while busy", 1, 0);
    if (req_valid && req_ready) outstanding++;
    // R3: selected only with work outstanding
    if (selected && outstanding == 0 && !rsp_valid) check(0, "R3", "select while idle", 1, 0);
    // R4: read strobe length
    if (!mem_oe_n) oe_low++;
    else if (!prev_oe_n) begin
      check(oe_low == RD_EXP, "R4", "oe low cycles", oe_low, RD_EXP);
      oe_low = 0;
    end
    // R6/R7: write pulse length and hold
    if (!mem_we_n) we_low++;
    else if (!prev_we_n) begin
      check(we_low == WP_EXP, "R6", "we low cycles", we_low, WP_EXP);
      check(selected && mem_dq_oe, "R7", "hold after we rise", {mem_dq_oe, selected}, 2'b11);
      we_low = 0;
    end
    if (!mem_we_n && !mem_oe_n) check(0, "R6", "oe low in write", 0, 1);
    // R8: turnaround
    if (!mem_oe_n) oe_off = 0; else if (oe_off < 99) oe_off++;
    if (mem_dq_oe && !mem_oe_n) check(0, "R8", "driver overlaps oe", 1, 0);
    if (mem_dq_oe && !prev_dq_oe && oe_off < 99)
      check(oe_off >= GAP_EXP + 2, "R8", "idle gap before drive", oe_off, GAP_EXP + 2);
    if (rsp_valid && !mem_oe_n) check(0, "R5", "oe still low at response", 0, 1);
    prev_dq_oe = mem_dq_oe; prev_we_n = mem_we_n; prev_oe_n = mem_oe_n;
  end

  // ---------------- watchdog ----------------
  initial begin
    #(200000 * 20);
    check(0, "R2", "watchdog expired", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    #25;
    @(negedge clk);
    check(mem_sel_n === 1 && mem_sel === 0, "R1", "selects in reset", {mem_sel_n, mem_sel}, 2'b10);
    check(mem_oe_n === 1 && mem_we_n === 1 && mem_dq_oe === 0, "R1", "strobes in reset",
          {mem_oe_n, mem_we_n, mem_dq_oe}, 3'b110);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready === 1 && rsp_valid === 0, "R1", "ready after reset", {req_ready, rsp_valid}, 2'b10);

    do_req(1, 21'h000000, 8'hA5);
    do_req(1, 21'h1FFFFF, 8'h3C);
    do_req(1, 21'h0AAAAA, 8'hFF);
    do_req(1, 21'h155555, 8'h00);
    do_req(0, 21'h000000, 0);
    do_req(0, 21'h1FFFFF, 0);
    do_req(1, 21'h000123, 8'h5A);   // read followed by write: R8 gap
    do_req(0, 21'h0AAAAA, 0);
    do_req(0, 21'h155555, 0);
    do_req(1, 21'h000000, 8'h81);   // overwrite
    do_req(0, 21'h000000, 0);
    do_req(0, 21'h000123, 0);
    for (int i = 0; i < 8; i++) do_req(1, 21'(i * 4099), 8'(i * 37 + 1));
    for (int i = 7; i >= 0; i--) do_req(0, 21'(i * 4099), 0);

    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R5", "all responses seen", exp_q.size(), 0);
    check(req_ready === 1 && selected == 0, "R3", "idle after drain", {req_ready, selected}, 2'b10);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule